// File: doc/BRIEF.md
# Pulse-Mode Conversion Clock Sequencer

This block drives the conversion clock of a sampling converter that runs in one-shot pulse mode rather than from a free-running clock. It runs from a fast system clock. A two-bit mode input picks one of three strobe schemes: clock resting high with one low pulse, clock resting low with two high pulses, or clock resting high with two low pulses. Pulse width, the phase between the two pulses, and the extra output delay are counts of system-clock cycles set by parameters. Elaboration checks keep these counts at or above the 20 ns floor the converter needs.

A `start` request taken while the sequencer is idle launches the pulse train. `busy` covers the whole conversion. A single-cycle `data_valid` marks the cycle when the converted word has settled in the converter's output registers. In the one-pulse scheme the converter rests in its sample phase, so its held charge droops. A monitor therefore raises a sticky `droop_err` flag when too long an idle time passes after a conversion in that scheme.

Top module: `pulse_conv_seq`

## Requirements
- R1: While reset is held and just after it, `adc_clk` is 1 and `busy`, `data_valid` and `droop_err` are 0.
- R2: Mode 2'b00 (2'b11 acts the same): `adc_clk` rests at 1. A conversion is one low pulse of PULSE_CYC cycles, and it begins on the clock edge that samples `start`.
- R3: Mode 2'b01: `adc_clk` rests at 0. A conversion is two high pulses of PULSE_CYC cycles each, with GAP_CYC low cycles between them.
- R4: Mode 2'b10: `adc_clk` rests at 1. A conversion is two low pulses of PULSE_CYC cycles each, with GAP_CYC high cycles between them.
- R5: `data_valid` is high for exactly one cycle, 1+OUT_DLY cycles after the transfer edge. The transfer edge is the end of the only pulse in mode 00, the start of the second pulse in mode 01, and the end of the second pulse in mode 10.
- R6: `busy` rises on the edge that accepts `start`. It stays high until the edge that raises `data_valid`, and it is low in the cycle `data_valid` is high.
- R7: A `start` while `busy` is high is ignored. The pulse train and `data_valid` stay as for a single request.
- R8: `mode` is sampled only while idle. A change during a conversion does not alter that conversion. While idle, `adc_clk` moves to the new mode's rest level one cycle after `mode` changes.
- R9: After a conversion in mode 00/11, DROOP_CYC cycles after `data_valid` rises with no new `start`, `droop_err` goes high and stays high. An accepted `start` clears it on the next edge.
- R10: `droop_err` is not raised after a mode 01 or mode 10 conversion. The monitor is disarmed if `mode` leaves 00/11 while idle.
- R11: A `start` presented in the cycle that `data_valid` is high is accepted on the next edge, so conversions can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start | input | 1 | conversion request, taken while idle |
| mode | input | 2 | strobe scheme: 00/11 one low pulse, 01 two high pulses, 10 two low pulses |
| adc_clk | output | 1 | registered converter clock |
| busy | output | 1 | conversion in progress |
| data_valid | output | 1 | one-cycle pulse when the result is in place |
| droop_err | output | 1 | sticky flag for an over-long sample-phase rest |

## Verification
Cycle k is counted from the edge that takes `start`. With the default counts of 4/4/3, the pulse edges fall at k=0 and k=4 in every mode, plus k=8 and k=12 in the two-pulse modes. `data_valid` is due at k=8, 12 and 16 for modes 00, 01 and 10, and `droop_err` is due DROOP_CYC cycles after `data_valid`. The bench drives and samples on the falling edge. It compares every cycle of the pulse train against a waveform computed from the parameters. It probes the exact cycle on both sides of each expected edge, so a result one cycle early or late is caught.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   typedef enum logic [1:0] {
      MODE_ONE_LOW  = 2'b00,
      MODE_TWO_HIGH = 2'b01,
      MODE_TWO_LOW  = 2'b10,
      MODE_ONE_ALT  = 2'b11
   } conv_mode_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_P1,
      ST_GAP,
      ST_P2,
      ST_WAIT
   } seq_state_t;

   function automatic logic rest_level(conv_mode_t m);
      return (m == MODE_TWO_HIGH) ? 1'b0 : 1'b1;
   endfunction

   function automatic logic two_pulse(conv_mode_t m);
      return (m == MODE_TWO_HIGH) || (m == MODE_TWO_LOW);
   endfunction

   function automatic logic droop_mode(conv_mode_t m);
      return (m == MODE_ONE_LOW) || (m == MODE_ONE_ALT);
   endfunction

endpackage

// File: rtl/pcs_valid_delay.sv
module pcs_valid_delay #(
   parameter int OUT_DLY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic due,
   output logic dv
);

   logic pend;

   generate
      if (OUT_DLY == 0) begin : g_nodly
         assign due = pend;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pend <= 1'b0;
            else if (load)  pend <= 1'b1;
            else if (due)   pend <= 1'b0;
         end
      end else begin : g_dly
         localparam int DW = $clog2(OUT_DLY + 1);
         logic [DW-1:0] cnt;
         assign due = pend && (cnt == '0);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend <= 1'b0;
               cnt  <= '0;
            end else if (load) begin
               pend <= 1'b1;
               cnt  <= DW'(OUT_DLY);
            end else if (due) begin
               pend <= 1'b0;
            end else if (pend) begin
               cnt  <= cnt - 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dv <= 1'b0;
      else        dv <= due;
   end

   assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dv |=> !dv);

endmodule

// File: rtl/pcs_sequencer.sv
module pcs_sequencer
   import pcs_pkg::*;
#(
   parameter int PULSE_CYC = 4,
   parameter int GAP_CYC   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  conv_mode_t mode_in,
   input  logic       due,
   output logic       xfer,
   output logic       adc_clk,
   output logic       busy,
   output logic       idle,
   output conv_mode_t mode_q
);

   localparam int PW = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
   localparam int CW = $clog2(PW + 1);

   seq_state_t    state;
   logic [CW-1:0] cnt;
   logic          clk_r;
   logic          busy_r;
   logic          last;

   assign last    = (cnt == '0);
   assign idle    = (state == ST_IDLE);
   assign adc_clk = clk_r;
   assign busy    = busy_r;

   always_comb begin
      xfer = 1'b0;
      unique case (state)
         ST_P1:   xfer = last && !two_pulse(mode_q);
         ST_GAP:  xfer = last && (mode_q == MODE_TWO_HIGH);
         ST_P2:   xfer = last && (mode_q == MODE_TWO_LOW);
         default: xfer = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         clk_r  <= 1'b1;
         busy_r <= 1'b0;
         mode_q <= MODE_ONE_LOW;
      end else begin
         unique case (state)
            ST_IDLE: begin
               mode_q <= mode_in;
               if (start) begin
                  state  <= ST_P1;
                  cnt    <= CW'(PULSE_CYC - 1);
                  clk_r  <= ~rest_level(mode_in);
                  busy_r <= 1'b1;
               end else begin
                  clk_r  <= rest_level(mode_in);
               end
            end
            ST_P1: begin
               if (last) begin
                  clk_r <= rest_level(mode_q);
                  if (two_pulse(mode_q)) begin
                     state <= ST_GAP;
                     cnt   <= CW'(GAP_CYC - 1);
                  end else begin
                     state <= ST_WAIT;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_GAP: begin
               if (last) begin
                  state <= ST_P2;
                  cnt   <= CW'(PULSE_CYC - 1);
                  clk_r <= ~rest_level(mode_q);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_P2: begin
               if (last) begin
                  state <= ST_WAIT;
                  clk_r <= rest_level(mode_q);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: ;
         endcase
         if (due) begin
            state  <= ST_IDLE;
            busy_r <= 1'b0;
         end
      end
   end

   assert_first_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && start) |=> (clk_r != rest_level(mode_q)));

   assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && $past(idle)) |-> (clk_r == rest_level(mode_q)));

   assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> $stable(mode_q));

   assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && !due) |=> busy_r);

   assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && start && !due) |=> !idle);

endmodule

// File: rtl/pcs_droop_monitor.sv
module pcs_droop_monitor #(
   parameter bit DROOP_EN  = 1'b1,
   parameter int DROOP_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_acc,
   input  logic arm,
   input  logic conv_droop,
   input  logic mode_droop,
   output logic droop_err
);

   generate
      if (!DROOP_EN) begin : g_off
         assign droop_err = 1'b0;
      end else begin : g_on
         localparam int TW = $clog2(DROOP_CYC + 1);
         logic [TW-1:0] tmr;
         logic          armed;
         logic          err_r;

         assign droop_err = err_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tmr   <= '0;
               armed <= 1'b0;
               err_r <= 1'b0;
            end else if (start_acc) begin
               tmr   <= '0;
               armed <= 1'b0;
               err_r <= 1'b0;
            end else if (arm) begin
               tmr   <= '0;
               armed <= conv_droop;
            end else if (armed) begin
               if (!mode_droop) begin
                  armed <= 1'b0;
               end else if (tmr == TW'(DROOP_CYC - 1)) begin
                  armed <= 1'b0;
                  err_r <= 1'b1;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
         end

         assert_droop_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (err_r && !start_acc) |=> err_r);

         assert_droop_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
            start_acc |=> !err_r);

         assert_droop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!armed && !err_r) |=> !err_r);
      end
   endgenerate

endmodule

// File: rtl/pulse_conv_seq.sv
module pulse_conv_seq
   import pcs_pkg::*;
#(
   parameter int SYS_CLK_MHZ   = 200,
   parameter int MIN_PHASE_NS  = 20,
   parameter int PULSE_CYC     = 4,
   parameter int GAP_CYC       = 4,
   parameter int OUT_DLY       = 3,
   parameter bit DROOP_EN      = 1'b1,
   parameter int DROOP_CYC     = 1000
) (
   input  logic       sys_clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [1:0] mode,
   output logic       adc_clk,
   output logic       busy,
   output logic       data_valid,
   output logic       droop_err
);

   localparam int MIN_CYC = (MIN_PHASE_NS * SYS_CLK_MHZ + 999) / 1000;

   generate
      if (PULSE_CYC < MIN_CYC)      begin : g_bad_pulse $error("pulse width under phase floor"); end
      if (GAP_CYC < MIN_CYC)        begin : g_bad_gap   $error("gap under phase floor"); end
      if (OUT_DLY + 1 < PULSE_CYC)  begin : g_bad_dly   $error("output delay ends before second pulse"); end
      if (DROOP_EN && DROOP_CYC < 2) begin : g_bad_drp  $error("droop limit too small"); end
   endgenerate

   conv_mode_t mode_in;
   conv_mode_t mode_q;
   logic       xfer;
   logic       due;
   logic       idle;
   logic       busy_i;
   logic       dv_i;

   assign mode_in = conv_mode_t'(mode);

   pcs_sequencer #(
      .PULSE_CYC (PULSE_CYC),
      .GAP_CYC   (GAP_CYC)
   ) u_seq (
      .clk     (sys_clk),
      .rst_n   (rst_n),
      .start   (start),
      .mode_in (mode_in),
      .due     (due),
      .xfer    (xfer),
      .adc_clk (adc_clk),
      .busy    (busy_i),
      .idle    (idle),
      .mode_q  (mode_q)
   );

   pcs_valid_delay #(
      .OUT_DLY (OUT_DLY)
   ) u_dly (
      .clk   (sys_clk),
      .rst_n (rst_n),
      .load  (xfer),
      .due   (due),
      .dv    (dv_i)
   );

   pcs_droop_monitor #(
      .DROOP_EN  (DROOP_EN),
      .DROOP_CYC (DROOP_CYC)
   ) u_droop (
      .clk        (sys_clk),
      .rst_n      (rst_n),
      .start_acc  (idle && start),
      .arm        (due),
      .conv_droop (droop_mode(mode_q)),
      .mode_droop (droop_mode(mode_in)),
      .droop_err  (droop_err)
   );

   assign busy       = busy_i;
   assign data_valid = dv_i;

   assert_valid_ends_busy_R6: assert property (@(posedge sys_clk) disable iff (!rst_n)
      data_valid |-> !busy);

   assert_valid_needs_busy_R5: assert property (@(posedge sys_clk) disable iff (!rst_n)
      $rose(data_valid) |-> $fell(busy));

endmodule

// File: tb/pulse_conv_seq_tb.sv
module pulse_conv_seq_tb;

   localparam int P = 4;
   localparam int G = 4;
   localparam int D = 3;
   localparam int DR = 1000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       adc_clk, busy, data_valid, droop_err;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   pulse_conv_seq #(
      .PULSE_CYC (P), .GAP_CYC (G), .OUT_DLY (D), .DROOP_CYC (DR)
   ) u_dut (
      .sys_clk (clk), .rst_n (rst_n), .start (start), .mode (mode),
      .adc_clk (adc_clk), .busy (busy), .data_valid (data_valid), .droop_err (droop_err)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         bad   = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: run hung, actual=%0d expected=<150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic rest_of(input logic [1:0] m);
      return (m == 2'b01) ? 1'b0 : 1'b1;
   endfunction

   function automatic logic exp_clk(input logic [1:0] m, input int k);
      logic in_p;
      in_p = (k >= 0 && k < P) ||
             ((m == 2'b01 || m == 2'b10) && k >= P + G && k < 2 * P + G);
      return rest_of(m) ^ in_p;
   endfunction

   function automatic int lat(input logic [1:0] m);
      if (m == 2'b01) return P + G + 1 + D;
      if (m == 2'b10) return 2 * P + G + 1 + D;
      return P + 1 + D;
   endfunction

   // one conversion; xs: cycle to re-assert start, mf: cycle to flip mode
   task automatic run_conv(input logic [1:0] m, input string req, input int xs, input int mf);
      int L, clk_bad, bsy_bad, dv_bad, first_k, act_c;
      logic [1:0] now_m;
      L = lat(m);
      clk_bad = 0; bsy_bad = 0; dv_bad = 0; first_k = -1; act_c = 0;
      mode = m;
      @(negedge clk);
      chk(adc_clk == rest_of(m), "R8", "idle level after mode set", adc_clk, rest_of(m));
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k <= L; k++) begin
         if (adc_clk !== exp_clk(m, k)) begin
            clk_bad++;
            if (first_k < 0) begin first_k = k; act_c = adc_clk; end
         end
         if (busy !== (k < L)) bsy_bad++;
         if (data_valid !== (k == L)) dv_bad++;
         start = (k == xs);
         if (k == mf) mode = ~m;
         @(negedge clk);
      end
      start = 1'b0;
      now_m = mode;
      chk(clk_bad == 0, req, $sformatf("pulse train mode %0d mismatch cycles (first k=%0d val=%0d)", m, first_k, act_c), clk_bad, 0);
      chk(bsy_bad == 0, "R6", $sformatf("busy window mode %0d mismatch cycles", m), bsy_bad, 0);
      chk(dv_bad == 0, "R5", $sformatf("data_valid timing mode %0d mismatch cycles", m), dv_bad, 0);
      chk(data_valid == 1'b0 && busy == 1'b0, "R7", "no second conversion after valid", {data_valid, busy}, 0);
      chk(adc_clk == rest_of(now_m), "R8", "idle level after conversion", adc_clk, rest_of(now_m));
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      wait_cyc(3);
      chk(adc_clk == 1'b1, "R1", "adc_clk in reset", adc_clk, 1);
      chk({busy, data_valid, droop_err} == 3'b000, "R1", "flags in reset", {busy, data_valid, droop_err}, 0);
      rst_n = 1'b1;
      wait_cyc(2);
      chk(adc_clk == 1'b1 && busy == 1'b0, "R1", "state after release", {adc_clk, busy}, 2);
   endtask

   task automatic t_modes;
      run_conv(2'b00, "R2", -1, -1);
      run_conv(2'b11, "R2", -1, -1);
      run_conv(2'b01, "R3", -1, -1);
      run_conv(2'b10, "R4", -1, -1);
   endtask

   task automatic t_busy_start;
      run_conv(2'b00, "R7", 2, -1);
      run_conv(2'b10, "R7", 9, -1);
   endtask

   task automatic t_mode_change;
      run_conv(2'b00, "R8", -1, 1);
      run_conv(2'b01, "R8", -1, 6);
   endtask

   task automatic t_back_to_back;
      int L;
      L = lat(2'b00);
      mode = 2'b00;
      wait_cyc(2);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_cyc(L);
      chk(data_valid == 1'b1, "R11", "first valid", data_valid, 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(adc_clk == 1'b0 && busy == 1'b1, "R11", "second start taken at once", {adc_clk, busy}, 1);
      wait_cyc(L - 1);
      chk(data_valid == 1'b0, "R11", "second valid not early", data_valid, 0);
      @(negedge clk);
      chk(data_valid == 1'b1, "R11", "second valid on time", data_valid, 1);
      wait_cyc(2);
   endtask

   task automatic t_droop;
      run_conv(2'b00, "R2", -1, -1);
      // now at k = L+1; droop due at k = L+DR
      wait_cyc(DR - 2);
      chk(droop_err == 1'b0, "R9", "droop one cycle before limit", droop_err, 0);
      @(negedge clk);
      chk(droop_err == 1'b1, "R9", "droop at limit", droop_err, 1);
      wait_cyc(7);
      chk(droop_err == 1'b1, "R9", "droop sticky", droop_err, 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(droop_err == 1'b0, "R9", "droop cleared by start", droop_err, 0);
      wait_cyc(lat(2'b00) + 2);
   endtask

   task automatic t_no_droop;
      run_conv(2'b01, "R3", -1, -1);
      wait_cyc(DR + 5);
      chk(droop_err == 1'b0, "R10", "no droop after two-high conversion", droop_err, 0);
      run_conv(2'b10, "R4", -1, -1);
      wait_cyc(DR + 5);
      chk(droop_err == 1'b0, "R10", "no droop after two-low conversion", droop_err, 0);
      run_conv(2'b00, "R2", -1, -1);
      mode = 2'b01;
      wait_cyc(20);
      mode = 2'b00;
      wait_cyc(DR + 5);
      chk(droop_err == 1'b0, "R10", "monitor disarmed by mode leave", droop_err, 0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_modes();
      t_busy_start();
      t_mode_change();
      t_back_to_back();
      t_droop();
      t_no_droop();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule